// File: doc/BRIEF.md
# Exception Lifecycle Sequencer

This block tracks the life of every exception vector in an interrupt controller. For each vector it holds a pending bit and an active bit, and for each external interrupt line it holds the last sampled level. Each clock it can carry out one of four strobed operations: complete a handler, acknowledge a pending vector, set a vector pending, or clear a pending vector. Alongside that operation it samples the external lines and the timer tick input.

External line n drives vector 16+n. A rising edge on a line pends its vector. When a handler for an external vector completes while its line is still high, the vector is pended again, so a held line re-runs its handler until the line drops. The synchronous fault vectors (3 to 13) cannot stay pending when they cannot be taken. Such a request is redirected to the hard fault vector (3) and a sticky escalation flag is set. If the current execution priority is negative, the redirection cannot be taken either, and a sticky lockup flag is raised instead.

A separate resolver computes the execution priority and supplies it. That resolver also owns the enable bits and the configurable priorities; this block only reads them.

Top module: `exc_lifecycle_seq`

## Requirements
- R1: After reset, pending, active, line_level, cur_exc, forced, lockup and bad_return are all zero, and ret_base is one.
- R2: A rising edge on ext_lines[n] sets pending bit 16+n at the next clock edge. A falling edge changes only line_level[n] and leaves pending untouched. An edge-driven set wins over a clear or acknowledge of the same vector in that cycle.
- R3: While tick is high, pending bit 15 is set at every clock edge, including when a clear of vector 15 is requested in the same cycle.
- R4: An acknowledge of a vector that is both enabled and pending sets its active bit, clears its pending bit and loads its number into cur_exc. Any other acknowledge changes no state.
- R5: A complete of a vector whose active bit is clear pulses bad_return for one cycle and changes no active bit and no ret_base.
- R6: A complete of an active vector clears its active bit. If the vector is external (16 or above) and its stored line level is high, the vector is set pending again.
- R7: On a valid complete, ret_base is loaded with 1 when at most one vector was active before the clear, and with 0 when two or more were.
- R8: A set-pending of vector 3 to 13 escalates when that vector is disabled or when its priority is at or above exec_prio (a lower value is more urgent). Vector 3 counts as priority -1, and vectors 4 to 13 take their priority from sync_prio. An escalation pends vector 3 instead and sets the sticky forced flag.
- R9: An escalation that occurs while exec_prio is negative sets the sticky lockup flag and pends nothing.
- R10: A set-pending of vector 14 or above, external vectors included, is never escalated, whatever exec_prio is.
- R11: A clear-pending request clears that vector's pending bit.
- R12: Only one strobed operation is carried out per clock, in the order complete, acknowledge, set, clear. An acknowledge in the same cycle as a complete is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_lines | input | NUM_EXT | External interrupt line levels |
| tick | input | 1 | Timer tick request (level) |
| set_req | input | 1 | Set-pending strobe |
| set_vec | input | VW | Vector to set pending |
| clr_req | input | 1 | Clear-pending strobe |
| clr_vec | input | VW | Vector to clear |
| ack_req | input | 1 | Acknowledge strobe |
| ack_vec | input | VW | Vector selected for acknowledge |
| cmp_req | input | 1 | Handler-complete strobe |
| cmp_vec | input | VW | Vector whose handler completes |
| vec_en | input | NVEC | Per-vector enable bits |
| sync_prio | input | 10*PRIO_W | Priorities of vectors 4..13, vector 4 in the low field |
| exec_prio | input | PRIO_W+2 | Signed current execution priority |
| pending | output | NVEC | Pending bits |
| active | output | NVEC | Active bits |
| line_level | output | NUM_EXT | Stored external line levels |
| cur_exc | output | VW | Most recently acknowledged vector |
| forced | output | 1 | Sticky escalation flag |
| lockup | output | 1 | Sticky lockup flag |
| bad_return | output | 1 | One-cycle pulse on a complete of a non-active vector |
| ret_base | output | 1 | Return-to-base value from the last valid complete |

## Verification
The set path is driven three ways. A fault vector below the execution priority must land on its own pending bit. The same vector at or above the execution priority, and a disabled one, must both land on vector 3 with the forced flag. An external vector with a negative execution priority must not escalate at all. The line path is tried with a line held high across a handler exit and then with a line dropped before exit, which separates re-pending from edge capture. Completes are issued with one vector active, with two active and with none, which covers both ret_base values and the illegal return. Same-cycle collisions (tick against clear, complete against acknowledge) confirm the stated precedence.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;
   localparam int unsigned FIRST_EXT_VEC  = 16;
   localparam int unsigned HARD_VEC       = 3;
   localparam int unsigned SYNC_FIRST_CFG = 4;
   localparam int unsigned SYNC_END_VEC   = 14;
   localparam int unsigned TICK_VEC       = 15;
   localparam int unsigned NUM_SYNC_CFG   = SYNC_END_VEC - SYNC_FIRST_CFG;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_COMPLETE,
      OP_ACK,
      OP_SET,
      OP_CLEAR
   } seq_op_e;
endpackage

// File: rtl/exc_line_edge.sv
`timescale 1ns/1ps
module exc_line_edge #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o
);
   for (genvar i = 0; i < N; i++) begin : g_line
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= lines_i[i];
      end
      assign level_o[i] = lvl_q;
      assign rise_o[i]  = lines_i[i] & ~lvl_q;
   end
endmodule

// File: rtl/exc_escalate.sv
`timescale 1ns/1ps
module exc_escalate
   import exc_seq_pkg::*;
#(
   parameter int NVEC = 24,
   parameter int VW   = 5,
   parameter int PW   = 8
) (
   input  logic [VW-1:0]              vec_i,
   input  logic [NVEC-1:0]            en_i,
   input  logic [NUM_SYNC_CFG*PW-1:0] prio_i,
   input  logic signed [PW+1:0]       exec_i,
   output logic                       escalate_o,
   output logic                       lockup_o
);
   logic               is_sync;
   logic signed [PW+1:0] eff_prio;
   logic               en_hit;

   always_comb begin
      is_sync  = (vec_i == VW'(HARD_VEC));
      eff_prio = '1;
      for (int i = 0; i < int'(NUM_SYNC_CFG); i++) begin
         if (vec_i == VW'(int'(SYNC_FIRST_CFG) + i)) begin
            is_sync  = 1'b1;
            eff_prio = signed'({2'b00, prio_i[i*PW +: PW]});
         end
      end
   end

   assign en_hit     = |(en_i & (NVEC'(1) << vec_i));
   assign escalate_o = is_sync && ((eff_prio >= exec_i) || !en_hit);
   assign lockup_o   = escalate_o && (exec_i < 0);
endmodule

// File: rtl/exc_rtb_calc.sv
`timescale 1ns/1ps
module exc_rtb_calc #(
   parameter int NVEC         = 24,
   parameter bit USE_POPCOUNT = 1'b1
) (
   input  logic [NVEC-1:0] act_i,
   output logic            at_most_one_o
);
   if (USE_POPCOUNT) begin : g_pop
      assign at_most_one_o = ($countones(act_i) <= 1);
   end else begin : g_lowbit
      assign at_most_one_o = ((act_i & (act_i - NVEC'(1))) == '0);
   end
endmodule

// File: rtl/exc_lifecycle_seq.sv
`timescale 1ns/1ps
module exc_lifecycle_seq
   import exc_seq_pkg::*;
#(
   parameter int NUM_EXT      = 8,
   parameter int PRIO_W       = 8,
   parameter bit RTB_POPCOUNT = 1'b1,
   localparam int NVEC        = FIRST_EXT_VEC + NUM_EXT,
   localparam int VW          = $clog2(NVEC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_EXT-1:0]             ext_lines,
   input  logic                           tick,
   input  logic                           set_req,
   input  logic [VW-1:0]                  set_vec,
   input  logic                           clr_req,
   input  logic [VW-1:0]                  clr_vec,
   input  logic                           ack_req,
   input  logic [VW-1:0]                  ack_vec,
   input  logic                           cmp_req,
   input  logic [VW-1:0]                  cmp_vec,
   input  logic [NVEC-1:0]                vec_en,
   input  logic [NUM_SYNC_CFG*PRIO_W-1:0] sync_prio,
   input  logic signed [PRIO_W+1:0]       exec_prio,
   output logic [NVEC-1:0]                pending,
   output logic [NVEC-1:0]                active,
   output logic [NUM_EXT-1:0]             line_level,
   output logic [VW-1:0]                  cur_exc,
   output logic                           forced,
   output logic                           lockup,
   output logic                           bad_return,
   output logic                           ret_base
);
   if (NUM_EXT < 1 || NUM_EXT > 496) begin : g_bad_ext
      $error("NUM_EXT out of range");
   end
   if (PRIO_W < 2 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W out of range");
   end

   // one-hot select of a vector; vector 0 and out-of-range numbers select nothing
   function automatic logic [NVEC-1:0] vsel(input logic [VW-1:0] v);
      return (NVEC'(1) << v) & ~NVEC'(1);
   endfunction

   logic [NVEC-1:0] pend_q, pend_n, act_q, act_n;
   logic [VW-1:0]   cur_q, cur_n;
   logic            forced_q, forced_n, lock_q, lock_n, bad_q, bad_n, rtb_q, rtb_n;
   logic [NUM_EXT-1:0] rise, level;
   logic            esc, esc_lock, one_or_less;
   seq_op_e         op;

   exc_line_edge #(.N(NUM_EXT)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines_i(ext_lines), .level_o(level), .rise_o(rise)
   );

   exc_escalate #(.NVEC(NVEC), .VW(VW), .PW(PRIO_W)) u_esc (
      .vec_i(set_vec), .en_i(vec_en), .prio_i(sync_prio), .exec_i(exec_prio),
      .escalate_o(esc), .lockup_o(esc_lock)
   );

   exc_rtb_calc #(.NVEC(NVEC), .USE_POPCOUNT(RTB_POPCOUNT)) u_rtb (
      .act_i(act_q), .at_most_one_o(one_or_less)
   );

   always_comb begin
      if (cmp_req)      op = OP_COMPLETE;
      else if (ack_req) op = OP_ACK;
      else if (set_req) op = OP_SET;
      else if (clr_req) op = OP_CLEAR;
      else              op = OP_IDLE;
   end

   logic [NVEC-1:0] cmp_sel, ack_sel, set_sel, clr_sel, level_span, rise_span;
   assign cmp_sel    = vsel(cmp_vec);
   assign ack_sel    = vsel(ack_vec);
   assign set_sel    = vsel(set_vec);
   assign clr_sel    = vsel(clr_vec);
   assign level_span = {level, {FIRST_EXT_VEC{1'b0}}};
   assign rise_span  = {rise, {FIRST_EXT_VEC{1'b0}}};

   always_comb begin
      pend_n   = pend_q;
      act_n    = act_q;
      cur_n    = cur_q;
      forced_n = forced_q;
      lock_n   = lock_q;
      rtb_n    = rtb_q;
      bad_n    = 1'b0;
      unique case (op)
         OP_COMPLETE: begin
            if ((act_q & cmp_sel) != '0) begin
               rtb_n  = one_or_less;
               act_n  = act_q & ~cmp_sel;
               pend_n = pend_q | (cmp_sel & level_span);
            end else begin
               bad_n = 1'b1;
            end
         end
         OP_ACK: begin
            if ((ack_sel & pend_q & vec_en) != '0) begin
               act_n  = act_q | ack_sel;
               pend_n = pend_q & ~ack_sel;
               cur_n  = ack_vec;
            end
         end
         OP_SET: begin
            if (esc_lock) begin
               lock_n = 1'b1;
            end else if (esc) begin
               pend_n[HARD_VEC] = 1'b1;
               forced_n         = 1'b1;
            end else begin
               pend_n = pend_q | set_sel;
            end
         end
         OP_CLEAR: pend_n = pend_q & ~clr_sel;
         default: ;
      endcase
      pend_n = pend_n | rise_span;
      if (tick) pend_n[TICK_VEC] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         act_q    <= '0;
         cur_q    <= '0;
         forced_q <= 1'b0;
         lock_q   <= 1'b0;
         bad_q    <= 1'b0;
         rtb_q    <= 1'b1;
      end else begin
         pend_q   <= pend_n;
         act_q    <= act_n;
         cur_q    <= cur_n;
         forced_q <= forced_n;
         lock_q   <= lock_n;
         bad_q    <= bad_n;
         rtb_q    <= rtb_n;
      end
   end

   assign pending    = pend_q;
   assign active     = act_q;
   assign line_level = level;
   assign cur_exc    = cur_q;
   assign forced     = forced_q;
   assign lockup     = lock_q;
   assign bad_return = bad_q;
   assign ret_base   = rtb_q;
endmodule

// File: rtl/exc_lifecycle_seq_chk.sv
`timescale 1ns/1ps
module exc_lifecycle_seq_chk
   import exc_seq_pkg::*;
#(
   parameter int NUM_EXT = 8,
   localparam int NVEC   = FIRST_EXT_VEC + NUM_EXT,
   localparam int VW     = $clog2(NVEC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EXT-1:0] ext_lines,
   input logic               tick,
   input logic               ack_req,
   input logic [VW-1:0]      ack_vec,
   input logic               cmp_req,
   input logic [VW-1:0]      cmp_vec,
   input logic [NVEC-1:0]    vec_en,
   input logic [NVEC-1:0]    pending,
   input logic [NVEC-1:0]    active,
   input logic [NUM_EXT-1:0] line_level,
   input logic               forced,
   input logic               lockup,
   input logic               bad_return,
   input logic               ret_base
);
   logic [NVEC-1:0] ack_m, cmp_m;
   assign ack_m = (NVEC'(1) << ack_vec) & ~NVEC'(1);
   assign cmp_m = (NVEC'(1) << cmp_vec) & ~NVEC'(1);

   assert_ack_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !cmp_req && ((vec_en & pending & ack_m) != '0) |=> ((active & $past(ack_m)) != '0));
   assert_ack_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !cmp_req && ((vec_en & pending & ack_m) == '0) |=> $stable(active));
   assert_bad_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req && ((active & cmp_m) == '0) |=> bad_return && $stable(active) && $stable(ret_base));
   assert_good_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req && ((active & cmp_m) != '0) |=> !bad_return && ((active & $past(cmp_m)) == '0));
   assert_rtb_multi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req && ((active & cmp_m) != '0) && ($countones(active) >= 2) |=> !ret_base);
   assert_tick_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> pending[TICK_VEC]);
   assert_forced_pends_hard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(forced) |-> pending[HARD_VEC]);
   assert_lockup_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lockup |=> lockup);

   for (genvar i = 0; i < NUM_EXT; i++) begin : g_rise
      assert_rise_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ext_lines[i] && !line_level[i] |=> pending[FIRST_EXT_VEC + i]);
   end
endmodule

bind exc_lifecycle_seq exc_lifecycle_seq_chk #(.NUM_EXT(NUM_EXT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .tick(tick),
   .ack_req(ack_req), .ack_vec(ack_vec), .cmp_req(cmp_req), .cmp_vec(cmp_vec),
   .vec_en(vec_en), .pending(pending), .active(active), .line_level(line_level),
   .forced(forced), .lockup(lockup), .bad_return(bad_return), .ret_base(ret_base)
);

// File: tb/exc_lifecycle_seq_test.sv
`timescale 1ns/1ps
module exc_lifecycle_seq_test;
   localparam int NEXT = 8;
   localparam int NV   = 16 + NEXT;
   localparam int VWB  = $clog2(NV);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NEXT-1:0] ext_lines = '0;
   logic tick = 1'b0;
   logic set_req = 1'b0, clr_req = 1'b0, ack_req = 1'b0, cmp_req = 1'b0;
   logic [VWB-1:0] set_vec = '0, clr_vec = '0, ack_vec = '0, cmp_vec = '0;
   logic [NV-1:0] vec_en;
   logic [10*8-1:0] sync_prio;
   logic signed [9:0] exec_prio = 10'sd256;
   logic [NV-1:0] pending, active;
   logic [NEXT-1:0] line_level;
   logic [VWB-1:0] cur_exc;
   logic forced, lockup, bad_return, ret_base;

   int total = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   exc_lifecycle_seq #(.NUM_EXT(NEXT), .PRIO_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .ext_lines(ext_lines), .tick(tick),
      .set_req(set_req), .set_vec(set_vec), .clr_req(clr_req), .clr_vec(clr_vec),
      .ack_req(ack_req), .ack_vec(ack_vec), .cmp_req(cmp_req), .cmp_vec(cmp_vec),
      .vec_en(vec_en), .sync_prio(sync_prio), .exec_prio(exec_prio),
      .pending(pending), .active(active), .line_level(line_level), .cur_exc(cur_exc),
      .forced(forced), .lockup(lockup), .bad_return(bad_return), .ret_base(ret_base)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // op: 0 set, 1 clear, 2 acknowledge, 3 complete
   task automatic do_op(input int op, input int v, input int ep);
      @(negedge clk);
      exec_prio = 10'(ep);
      case (op)
         0: begin set_req = 1'b1; set_vec = VWB'(v); end
         1: begin clr_req = 1'b1; clr_vec = VWB'(v); end
         2: begin ack_req = 1'b1; ack_vec = VWB'(v); end
         default: begin cmp_req = 1'b1; cmp_vec = VWB'(v); end
      endcase
      @(negedge clk);
      set_req = 1'b0; clr_req = 1'b0; ack_req = 1'b0; cmp_req = 1'b0;
   endtask

   typedef struct packed {
      int op; int v; int ep; int cv; int pend; int act; int frc;
   } row_t;

   // vector v has priority 8*v; vector 6 is disabled
   localparam row_t TBL [11] = '{
      '{0,  5, 256,  5, 1, 0, 0},  // R8 sync set below exec priority
      '{2,  5, 256,  5, 0, 1, 0},  // R4 acknowledge
      '{0,  4,  40,  4, 1, 0, 0},  // R8 32 < 40 no escalation
      '{0,  5,  32,  3, 1, 0, 1},  // R8 40 >= 32 escalates to vector 3
      '{0,  6, 256,  6, 0, 0, 1},  // R8 disabled vector escalates
      '{2,  3, 256,  3, 0, 1, 1},  // R4 acknowledge hard fault
      '{3,  3, 256,  3, 0, 0, 1},  // R6 complete
      '{1,  4, 256,  4, 0, 0, 1},  // R11 clear
      '{2,  4, 256,  4, 0, 0, 1},  // R4 acknowledge of non-pending ignored
      '{0, 20,  -1, 20, 1, 0, 1},  // R10 external vector never escalates
      '{3,  5, 256,  5, 0, 0, 1}   // R6 complete
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      vec_en = '1;
      vec_en[6] = 1'b0;
      for (int v = 4; v < 14; v++) sync_prio[(v-4)*8 +: 8] = 8'(v*8);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pending", int'(pending), 0);
      check("R1 active", int'(active), 0);
      check("R1 cur_exc", int'(cur_exc), 0);
      check("R1 ret_base", int'(ret_base), 1);
      check("R1 flags", int'({forced, lockup, bad_return}), 0);

      for (int r = 0; r < 11; r++) begin
         do_op(TBL[r].op, TBL[r].v, TBL[r].ep);
         check($sformatf("table row %0d pend", r), int'(pending[TBL[r].cv]), TBL[r].pend);
         check($sformatf("table row %0d act", r), int'(active[TBL[r].cv]), TBL[r].act);
         check($sformatf("table row %0d forced", r), int'(forced), TBL[r].frc);
         if (r == 1) check("R4 cur_exc", int'(cur_exc), 5);
         if (r == 3) check("R8 vector 5 not pended", int'(pending[5]), 0);
         if (r == 9) check("R10 no lockup", int'(lockup), 0);
      end

      // R4 acknowledge loads cur_exc
      do_op(0, 7, 256);
      do_op(2, 7, 256);
      check("R4 cur_exc 7", int'(cur_exc), 7);

      // R2 rising edge on line 2 pends vector 18
      @(negedge clk); ext_lines[2] = 1'b1;
      @(negedge clk);
      check("R2 rise pends 18", int'(pending[18]), 1);
      check("R2 level high", int'(line_level[2]), 1);
      do_op(2, 18, 256);
      check("R4 ack 18 clears pend", int'(pending[18]), 0);
      // R6 complete while line high re-pends; R7 two active
      do_op(3, 18, 256);
      check("R6 re-pend 18", int'(pending[18]), 1);
      check("R6 act 18 cleared", int'(active[18]), 0);
      check("R7 two active", int'(ret_base), 0);

      // R2 falling edge only updates level
      @(negedge clk); ext_lines[2] = 1'b0;
      @(negedge clk);
      check("R2 level low", int'(line_level[2]), 0);
      check("R2 fall keeps pend", int'(pending[18]), 1);
      do_op(2, 18, 256);
      do_op(3, 18, 256);
      check("R6 no re-pend when low", int'(pending[18]), 0);
      do_op(3, 7, 256);
      check("R7 single active", int'(ret_base), 1);

      // R5 illegal return
      do_op(3, 9, 256);
      check("R5 bad_return pulse", int'(bad_return), 1);
      check("R5 active unchanged", int'(active), 0);
      check("R5 ret_base unchanged", int'(ret_base), 1);
      @(negedge clk);
      check("R5 pulse one cycle", int'(bad_return), 0);

      // R3 tick beats clear
      @(negedge clk); tick = 1'b1; clr_req = 1'b1; clr_vec = VWB'(15);
      @(negedge clk); tick = 1'b0; clr_req = 1'b0;
      check("R3 tick over clear", int'(pending[15]), 1);
      do_op(1, 15, 256);
      check("R11 clear 15", int'(pending[15]), 0);

      // R12 complete wins over acknowledge
      do_op(2, 20, 256);
      do_op(0, 16, 256);
      @(negedge clk);
      cmp_req = 1'b1; cmp_vec = VWB'(20); ack_req = 1'b1; ack_vec = VWB'(16);
      @(negedge clk);
      cmp_req = 1'b0; ack_req = 1'b0;
      check("R12 complete done", int'(active[20]), 0);
      check("R12 ack dropped", int'(active[16]), 0);
      check("R12 16 still pending", int'(pending[16]), 1);

      // R9 lockup at negative execution priority
      do_op(0, 4, -1);
      check("R9 lockup", int'(lockup), 1);
      check("R9 no hard pend", int'(pending[3]), 0);
      check("R9 no vec 4 pend", int'(pending[4]), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule